// File: doc/BRIEF.md
# Space-Variant Filter Coefficient Generator

This block produces, for every pixel of a feature map, the set of filter coefficients that a later non-linear convolution stage applies at that position. A frame of K-channel signed pixels is streamed in and held on chip. For each pixel, every output tap (n, m, p) of the W1×W1×K coefficient set gets its own raw value. That raw value is a zero-padded linear convolution of the frame with a trained W2×W2×K kernel that belongs only to that tap. The raw value passes through a pointwise activation. Once all taps of the pixel are held, each activated tap is divided by the pixel's tap sum plus a programmable epsilon, so the coefficient set has unit gain.

Trained kernels are written once through a simple write port. The normalised coefficients leave through a valid/ready stream, one tap per beat, with a flag on the final tap of each pixel. A parameter selects how the kernel sum is formed. One variant evaluates all W2×W2 products of a channel in a single cycle through an adder tree. The other variant uses one multiplier and walks the kernel window over several cycles.

Top module: `svw_weight_gen`

## Requirements
- R1: After reset `pix_ready` is high. Pixels are taken in raster order: row, then column, with the channel index fastest. `pix_ready` falls once IMG_H·IMG_W·K pixels have been accepted. `coef_valid` is never high while `pix_ready` is high.
- R2: The raw value of tap t at pixel (i,j) is the sum over q, r and s of x(i+r−o2, j+s−o2, q)·u_t(r,s,q), with o2=(W2−1)/2. Samples outside the frame count as zero, so coefficients are produced for every pixel of the frame.
- R3: With `act_sel`=0 a raw value ≤ 0 becomes 0 (rectifier). With `act_sel`=1 the raw value passes unchanged. In rectifier mode no emitted coefficient is negative.
- R4: The pixel's denominator is the sum of all T=W1·W1·K activated taps plus the unsigned `eps`. When `abs_mode`=1, the absolute values of the taps are summed instead.
- R5: Each coefficient equals the activated tap times 2^FRAC divided by the denominator, truncated toward zero. Its magnitude is clipped to 2^(OW−1)−1. A zero denominator yields that maximum magnitude, negative only if the tap is negative.
- R6: The taps of a pixel are emitted with tap index t=(n·W1+m)·K+p ascending, so p changes fastest. Pixels are emitted in raster order. `coef_last` is high exactly on the beat of t=T−1.
- R7: While `coef_valid` is high and `coef_ready` is low, `coef_valid`, `coef_data` and `coef_last` hold.
- R8: A write with `wt_we` stores `wt_data` as weight u_t(r,s,q) at address ((t·K+q)·W2+r)·W2+s.
- R9: When the last coefficient of the last pixel is accepted, `pix_ready` rises on the next cycle for the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_sel | input | 1 | 0: rectifier activation, 1: identity |
| abs_mode | input | 1 | 1: denominator sums absolute tap values |
| eps | input | EPSW | Unsigned constant added to the denominator |
| wt_we | input | 1 | Trained-weight write enable |
| wt_addr | input | WAW | Trained-weight write address |
| wt_data | input | FW | Signed trained weight |
| pix_valid | input | 1 | Input pixel valid |
| pix_ready | output | 1 | Block accepts pixels |
| pix_data | input | DW | Signed input pixel |
| coef_valid | output | 1 | Coefficient valid |
| coef_ready | input | 1 | Consumer accepts coefficient |
| coef_data | output | OW | Signed normalised coefficient, FRAC fraction bits |
| coef_last | output | 1 | Final tap of the current pixel |

## Verification
The bound checker watches, on every cycle, that a stalled coefficient beat keeps its valid, data and last flag. It also checks that loading and emission never overlap, that the last flag lands on every T-th accepted beat and only there, and that rectifier mode never produces a negative coefficient. The numbers themselves can only be shown by the bench scenarios, which compare each beat with a behavioural model. These scenarios cover padding at the frame edges, the per-tap kernels and tap order, and signed division with truncation and clipping. They also cover the absolute-sum denominator and the zero-denominator case, using a blank frame with epsilon zero under random backpressure.

// File: rtl/svw_pkg.sv
package svw_pkg;
   typedef enum logic [2:0] {
      ST_LOAD,
      ST_MAC,
      ST_ACT,
      ST_DGO,
      ST_DWAIT,
      ST_EMIT
   } svw_state_e;
endpackage

// File: rtl/svw_frame_buf.sv
// Holds one K-channel frame and returns the zero-padded W2xW2 window
// of one channel around a pixel.
module svw_frame_buf #(
   parameter int DW    = 8,
   parameter int K     = 2,
   parameter int IMG_H = 8,
   parameter int IMG_W = 8,
   parameter int W2    = 3,
   localparam int DEPTH = IMG_H * IMG_W * K,
   localparam int AW    = $clog2(DEPTH),
   localparam int RW    = $clog2(IMG_H),
   localparam int CW    = $clog2(IMG_W),
   localparam int QW    = (K > 1) ? $clog2(K) : 1
) (
   input  logic                 clk,
   input  logic                 wr_en,
   input  logic [AW-1:0]        wr_addr,
   input  logic [DW-1:0]        wr_data,
   input  logic [RW-1:0]        row,
   input  logic [CW-1:0]        col,
   input  logic [QW-1:0]        chan,
   output logic [W2*W2*DW-1:0]  win
);
   localparam int O2 = (W2 - 1) / 2;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   for (genvar gr = 0; gr < W2; gr++) begin : g_r
      for (genvar gs = 0; gs < W2; gs++) begin : g_s
         int            rr;
         int            cc;
         logic [DW-1:0] px;
         always_comb begin
            rr = int'(row) + gr - O2;
            cc = int'(col) + gs - O2;
            if (rr >= 0 && rr < IMG_H && cc >= 0 && cc < IMG_W)
               px = mem[AW'((rr * IMG_W + cc) * K + int'(chan))];
            else
               px = '0;
         end
         assign win[(gr*W2+gs)*DW +: DW] = px;
      end
   end
endmodule

// File: rtl/svw_tap_mac.sv
// Trained-kernel store and multiply-accumulate for one raw tap value.
// UNROLL=1: whole W2xW2 window of a channel per cycle through an adder tree.
// UNROLL=0: one product per cycle, window position chosen by rs_sel.
module svw_tap_mac #(
   parameter int DW     = 8,
   parameter int FW     = 8,
   parameter int K      = 2,
   parameter int W2     = 3,
   parameter int T      = 18,
   parameter int ACCW   = 22,
   parameter int UNROLL = 1,
   localparam int RS    = W2 * W2,
   localparam int WDEPTH = T * K * RS,
   localparam int WAW   = $clog2(WDEPTH),
   localparam int TW    = $clog2(T),
   localparam int QW    = (K > 1) ? $clog2(K) : 1,
   localparam int SW    = $clog2(RS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wt_we,
   input  logic [WAW-1:0]         wt_addr,
   input  logic signed [FW-1:0]   wt_data,
   input  logic [RS*DW-1:0]       win,
   input  logic [TW-1:0]          tap,
   input  logic [QW-1:0]          chan,
   input  logic [SW-1:0]          rs_sel,
   input  logic                   step,
   input  logic                   first,
   output logic signed [ACCW-1:0] acc
);
   logic signed [FW-1:0]   wmem [WDEPTH];
   logic [WAW-1:0]         base;
   logic signed [ACCW-1:0] part;

   always_ff @(posedge clk) begin
      if (wt_we) wmem[wt_addr] <= wt_data;
   end

   assign base = WAW'((int'(tap) * K + int'(chan)) * RS);

   if (UNROLL != 0) begin : g_par
      logic unused_rs;
      assign unused_rs = ^rs_sel;
      always_comb begin
         logic signed [DW+FW-1:0] prod;
         part = '0;
         for (int k = 0; k < RS; k++) begin
            prod = $signed(win[k*DW +: DW]) * wmem[base + WAW'(k)];
            part = part + ACCW'(prod);
         end
      end
   end else begin : g_ser
      always_comb begin
         logic signed [DW+FW-1:0] prod;
         prod = $signed(win[int'(rs_sel)*DW +: DW]) * wmem[base + WAW'(rs_sel)];
         part = ACCW'(prod);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc <= '0;
      else if (step) acc <= first ? part : acc + part;
   end
endmodule

// File: rtl/svw_div.sv
// Iterative restoring divider, one quotient bit per cycle, unsigned.
module svw_div #(
   parameter int NUMW = 30,
   parameter int DENW = 29
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [NUMW-1:0] num,
   input  logic [DENW-1:0] den,
   output logic            done,
   output logic [NUMW-1:0] quo
);
   localparam int CW = $clog2(NUMW + 1);

   logic [DENW:0]   rem;
   logic [DENW:0]   trial;
   logic [NUMW-1:0] dvd;
   logic [CW-1:0]   cnt;
   logic            busy;

   assign trial = {rem[DENW-1:0], dvd[NUMW-1]};
   assign quo   = dvd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem  <= '0;
         dvd  <= '0;
         cnt  <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            rem  <= '0;
            dvd  <= num;
            cnt  <= CW'(NUMW);
            busy <= 1'b1;
         end else if (busy) begin
            if (trial >= {1'b0, den}) begin
               rem <= trial - {1'b0, den};
               dvd <= {dvd[NUMW-2:0], 1'b1};
            end else begin
               rem <= trial;
               dvd <= {dvd[NUMW-2:0], 1'b0};
            end
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/svw_weight_gen.sv
module svw_weight_gen
   import svw_pkg::*;
#(
   parameter int DW     = 8,
   parameter int FW     = 8,
   parameter int K      = 2,
   parameter int W1     = 3,
   parameter int W2     = 3,
   parameter int IMG_H  = 8,
   parameter int IMG_W  = 8,
   parameter int OW     = 16,
   parameter int FRAC   = 8,
   parameter int EPSW   = 8,
   parameter int UNROLL = 1,
   localparam int WAW   = $clog2(W1 * W1 * K * K * W2 * W2)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                act_sel,
   input  logic                abs_mode,
   input  logic [EPSW-1:0]     eps,
   input  logic                wt_we,
   input  logic [WAW-1:0]      wt_addr,
   input  logic signed [FW-1:0] wt_data,
   input  logic                pix_valid,
   output logic                pix_ready,
   input  logic [DW-1:0]       pix_data,
   output logic                coef_valid,
   input  logic                coef_ready,
   output logic [OW-1:0]       coef_data,
   output logic                coef_last
);
   localparam int T     = W1 * W1 * K;
   localparam int RS    = W2 * W2;
   localparam int NTERM = RS * K;
   localparam int ACCW  = DW + FW + $clog2(NTERM) + 1;
   localparam int SUMW  = ACCW + $clog2(T) + 1;
   localparam int DENW  = SUMW + 1;
   localparam int NUMW  = ACCW + FRAC;
   localparam int FRAME = IMG_H * IMG_W * K;
   localparam int FAW   = $clog2(FRAME);
   localparam int RW    = $clog2(IMG_H);
   localparam int CW    = $clog2(IMG_W);
   localparam int QW    = (K > 1) ? $clog2(K) : 1;
   localparam int TW    = $clog2(T);
   localparam int SW    = $clog2(RS);
   localparam logic [OW-1:0] MAXP = {1'b0, {(OW-1){1'b1}}};

   if (W2 < 3 || (W2 % 2) == 0) begin : g_bad_w2
      $error("W2 must be odd and at least 3");
   end
   if (T < 2) begin : g_bad_t
      $error("W1*W1*K must be at least 2");
   end
   if (IMG_H < 2 || IMG_W < 2) begin : g_bad_img
      $error("image must be at least 2x2");
   end
   if (FRAC < 1 || NUMW < OW) begin : g_bad_frac
      $error("FRAC must be positive and ACCW+FRAC at least OW");
   end
   if (EPSW >= SUMW) begin : g_bad_eps
      $error("EPSW must be narrower than the tap sum");
   end

   svw_state_e             state;
   logic [FAW-1:0]         ld_cnt;
   logic [RW-1:0]          row;
   logic [CW-1:0]          col;
   logic [TW-1:0]          tap;
   logic [QW-1:0]          chan;
   logic [SW-1:0]          rs;
   logic signed [SUMW-1:0] sum_acc;
   logic signed [ACCW-1:0] tap_buf [T];
   logic [RS*DW-1:0]       win;
   logic signed [ACCW-1:0] acc;
   logic signed [ACCW-1:0] act_v;
   logic signed [SUMW-1:0] act_ext;
   logic signed [SUMW-1:0] act_add;
   logic                   last_term;
   logic                   win_step;
   logic signed [ACCW-1:0] numer_s;
   logic [ACCW-1:0]        numer_mag;
   logic signed [DENW-1:0] den_s;
   logic [DENW-1:0]        den_mag;
   logic                   div_done;
   logic [NUMW-1:0]        quo;
   logic [OW-1:0]          mag_sat;
   logic [OW-1:0]          coef_r;

   svw_frame_buf #(
      .DW(DW), .K(K), .IMG_H(IMG_H), .IMG_W(IMG_W), .W2(W2)
   ) u_fbuf (
      .clk     (clk),
      .wr_en   (state == ST_LOAD && pix_valid),
      .wr_addr (ld_cnt),
      .wr_data (pix_data),
      .row     (row),
      .col     (col),
      .chan    (chan),
      .win     (win)
   );

   svw_tap_mac #(
      .DW(DW), .FW(FW), .K(K), .W2(W2), .T(T), .ACCW(ACCW), .UNROLL(UNROLL)
   ) u_mac (
      .clk     (clk),
      .rst_n   (rst_n),
      .wt_we   (wt_we),
      .wt_addr (wt_addr),
      .wt_data (wt_data),
      .win     (win),
      .tap     (tap),
      .chan    (chan),
      .rs_sel  (rs),
      .step    (state == ST_MAC),
      .first   (chan == '0 && rs == '0),
      .acc     (acc)
   );

   svw_div #(.NUMW(NUMW), .DENW(DENW)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (state == ST_DGO),
      .num   ({numer_mag, {FRAC{1'b0}}}),
      .den   (den_mag),
      .done  (div_done),
      .quo   (quo)
   );

   // activation and denominator contribution
   assign act_v   = (!act_sel && acc[ACCW-1]) ? '0 : acc;
   assign act_ext = SUMW'(act_v);
   assign act_add = (abs_mode && act_ext[SUMW-1]) ? -act_ext : act_ext;

   assign win_step  = (UNROLL != 0) || (rs == SW'(RS - 1));
   assign last_term = win_step && (chan == QW'(K - 1));

   // division operands
   assign numer_s   = tap_buf[tap];
   assign numer_mag = numer_s[ACCW-1] ? ACCW'(-numer_s) : ACCW'(numer_s);
   assign den_s     = DENW'(sum_acc) + DENW'({1'b0, eps});
   assign den_mag   = den_s[DENW-1] ? DENW'(-den_s) : DENW'(den_s);
   assign mag_sat   = (quo > NUMW'(MAXP)) ? MAXP : quo[OW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_LOAD;
         ld_cnt  <= '0;
         row     <= '0;
         col     <= '0;
         tap     <= '0;
         chan    <= '0;
         rs      <= '0;
         sum_acc <= '0;
         coef_r  <= '0;
      end else begin
         unique case (state)
            ST_LOAD: if (pix_valid) begin
               if (ld_cnt == FAW'(FRAME - 1)) begin
                  ld_cnt  <= '0;
                  sum_acc <= '0;
                  state   <= ST_MAC;
               end else begin
                  ld_cnt <= ld_cnt + 1'b1;
               end
            end
            ST_MAC: begin
               if (last_term) begin
                  state <= ST_ACT;
               end else if (win_step) begin
                  rs   <= '0;
                  chan <= chan + 1'b1;
               end else begin
                  rs <= rs + 1'b1;
               end
            end
            ST_ACT: begin
               sum_acc <= sum_acc + act_add;
               chan    <= '0;
               rs      <= '0;
               if (tap == TW'(T - 1)) begin
                  tap   <= '0;
                  state <= ST_DGO;
               end else begin
                  tap   <= tap + 1'b1;
                  state <= ST_MAC;
               end
            end
            ST_DGO: state <= ST_DWAIT;
            ST_DWAIT: if (div_done) begin
               coef_r <= (numer_s[ACCW-1] ^ den_s[DENW-1]) ? OW'(-mag_sat) : mag_sat;
               state  <= ST_EMIT;
            end
            ST_EMIT: if (coef_ready) begin
               if (tap == TW'(T - 1)) begin
                  tap     <= '0;
                  sum_acc <= '0;
                  state   <= ST_MAC;
                  if (col == CW'(IMG_W - 1)) begin
                     col <= '0;
                     if (row == RW'(IMG_H - 1)) begin
                        row   <= '0;
                        state <= ST_LOAD;
                     end else begin
                        row <= row + 1'b1;
                     end
                  end else begin
                     col <= col + 1'b1;
                  end
               end else begin
                  tap   <= tap + 1'b1;
                  state <= ST_DGO;
               end
            end
            default: state <= ST_LOAD;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (state == ST_ACT) tap_buf[tap] <= act_v;
   end

   assign pix_ready  = (state == ST_LOAD);
   assign coef_valid = (state == ST_EMIT);
   assign coef_data  = coef_r;
   assign coef_last  = (state == ST_EMIT) && (tap == TW'(T - 1));
endmodule

// File: rtl/svw_weight_gen_chk.sv
module svw_weight_gen_chk #(
   parameter int OW = 16,
   parameter int T  = 18
) (
   input logic          clk,
   input logic          rst_n,
   input logic          pix_ready,
   input logic          coef_valid,
   input logic          coef_ready,
   input logic          coef_last,
   input logic          act_sel,
   input logic [OW-1:0] coef_data
);
   localparam int BW = $clog2(T);

   logic [BW-1:0] beat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) beat <= '0;
      else if (coef_valid && coef_ready)
         beat <= (beat == BW'(T - 1)) ? '0 : beat + 1'b1;
   end

   AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      coef_valid && !coef_ready |=> coef_valid); // R7
   AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      coef_valid && !coef_ready |=> $stable(coef_data) && $stable(coef_last)); // R7
   AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      pix_ready |-> !coef_valid); // R1
   AST_LAST_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      coef_valid && coef_last |-> beat == BW'(T - 1)); // R6
   AST_LAST_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
      coef_valid && beat == BW'(T - 1) |-> coef_last); // R6
   AST_RELU_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
      coef_valid && !act_sel |-> !coef_data[OW-1]); // R3
endmodule

bind svw_weight_gen svw_weight_gen_chk #(.OW(OW), .T(T)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pix_ready  (pix_ready),
   .coef_valid (coef_valid),
   .coef_ready (coef_ready),
   .coef_last  (coef_last),
   .act_sel    (act_sel),
   .coef_data  (coef_data)
);

// File: tb/sim_svw_weight_gen.sv
`timescale 1ns/1ps
module sim_svw_weight_gen;
   localparam int H = 8, W = 8, K = 2, W1 = 3, W2 = 3;
   localparam int T = W1 * W1 * K;
   localparam int OW = 16, FRAC = 8;
   localparam int WAW = $clog2(W1 * W1 * K * K * W2 * W2);
   localparam longint MAXP = (64'sd1 <<< (OW - 1)) - 1;

   logic clk = 1'b0;
   logic rst_n;
   logic act_sel, abs_mode;
   logic [7:0] eps;
   logic wt_we;
   logic [WAW-1:0] wt_addr;
   logic signed [7:0] wt_data;
   logic pix_valid, pix_ready;
   logic [7:0] pix_data;
   logic coef_valid, coef_ready, coef_last;
   logic [OW-1:0] coef_data;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 0;
   int px [H][W][K];
   int wt [T][K][W2][W2];
   longint exp_q [$];
   int beat = 0;
   string tag = "R1";

   always #4 clk = ~clk;

   svw_weight_gen u0 (
      .clk(clk), .rst_n(rst_n), .act_sel(act_sel), .abs_mode(abs_mode), .eps(eps),
      .wt_we(wt_we), .wt_addr(wt_addr), .wt_data(wt_data),
      .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
      .coef_valid(coef_valid), .coef_ready(coef_ready),
      .coef_data(coef_data), .coef_last(coef_last)
   );

   task automatic chk(bit ok, string req, longint act, longint expv);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // random backpressure on the coefficient stream (R7)
   always @(posedge clk) begin
      #1 coef_ready = ($urandom % 4) != 0;
   end

   // per-clock comparison against the model queue
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (coef_valid && pix_ready)
            chk(1'b0, "R1 overlap", 1, 0);
         if (coef_valid && coef_ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R6 unexpected beat", $signed(coef_data), 0);
            end else begin
               longint e;
               e = exp_q.pop_front();
               chk($signed(coef_data) == e, tag, $signed(coef_data), e);
               chk(coef_last == (beat == T - 1), "R6 last", coef_last, beat == T - 1);
               beat = (beat == T - 1) ? 0 : beat + 1;
            end
         end
      end
   end

   task automatic build_expect();
      for (int i = 0; i < H; i++)
         for (int j = 0; j < W; j++) begin
            longint a [T];
            longint den = 0;
            for (int t = 0; t < T; t++) begin
               longint s = 0;
               for (int q = 0; q < K; q++)
                  for (int r = 0; r < W2; r++)
                     for (int c = 0; c < W2; c++) begin
                        int rr = i + r - (W2 - 1) / 2;
                        int cc = j + c - (W2 - 1) / 2;
                        if (rr >= 0 && rr < H && cc >= 0 && cc < W)
                           s += px[rr][cc][q] * wt[t][q][r][c];
                     end
               if (!act_sel && s < 0) s = 0;
               a[t] = s;
               den += (abs_mode && s < 0) ? -s : s;
            end
            den += eps;
            for (int t = 0; t < T; t++) begin
               longint mag, na, nd;
               na = (a[t] < 0) ? -a[t] : a[t];
               nd = (den < 0) ? -den : den;
               if (nd == 0) mag = MAXP;
               else mag = (na <<< FRAC) / nd;
               if (mag > MAXP) mag = MAXP;
               exp_q.push_back(((a[t] < 0) != (den < 0)) ? -mag : mag);
            end
         end
   endtask

   task automatic run_frame(bit zero_img);
      for (int i = 0; i < H; i++)
         for (int j = 0; j < W; j++)
            for (int q = 0; q < K; q++)
               px[i][j][q] = zero_img ? 0 : int'($urandom_range(0, 255)) - 128;
      build_expect();
      for (int i = 0; i < H; i++)
         for (int j = 0; j < W; j++)
            for (int q = 0; q < K; q++) begin
               pix_valid = 1'b1;
               pix_data  = 8'(px[i][j][q]);
               do @(negedge clk); while (!pix_ready);
               @(posedge clk); #1;
            end
      pix_valid = 1'b0;
      @(negedge clk);
      chk(pix_ready == 1'b0, "R1 busy after load", pix_ready, 0);
      while (exp_q.size() != 0) @(posedge clk);
      @(negedge clk);
      chk(pix_ready == 1'b1, "R9 ready for next frame", pix_ready, 1);
      @(posedge clk); #1;
   endtask

   initial begin
      rst_n = 1'b0; act_sel = 1'b0; abs_mode = 1'b0; eps = 8'd1;
      wt_we = 1'b0; wt_addr = '0; wt_data = '0;
      pix_valid = 1'b0; pix_data = '0; coef_ready = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(pix_ready == 1'b1, "R1 reset ready", pix_ready, 1);
      chk(coef_valid == 1'b0, "R7 reset idle", coef_valid, 0);
      @(posedge clk); #1;
      // R8: weight layout ((t*K+q)*W2+r)*W2+s
      for (int t = 0; t < T; t++)
         for (int q = 0; q < K; q++)
            for (int r = 0; r < W2; r++)
               for (int c = 0; c < W2; c++) begin
                  wt[t][q][r][c] = int'($urandom_range(0, 255)) - 128;
                  wt_we   = 1'b1;
                  wt_addr = WAW'(((t * K + q) * W2 + r) * W2 + c);
                  wt_data = 8'(wt[t][q][r][c]);
                  @(posedge clk); #1;
               end
      wt_we = 1'b0;
      // rectifier, plain sum, eps 1
      tag = "R2 R3 R5 R7 R8 rectifier";
      act_sel = 1'b0; abs_mode = 1'b0; eps = 8'd1;
      run_frame(1'b0);
      // identity, absolute-sum denominator
      tag = "R2 R4 R5 identity abs";
      act_sel = 1'b1; abs_mode = 1'b1; eps = 8'd3;
      run_frame(1'b0);
      // blank frame, plain sum, eps 0: zero denominator
      tag = "R4 R5 zero denominator";
      act_sel = 1'b1; abs_mode = 1'b0; eps = 8'd0;
      run_frame(1'b1);
      if (!finished) begin
         finished = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         vectors++;
         miscompares++;
         $display("FAIL watchdog actual=%0d expected=%0d", exp_q.size(), 0);
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule